// File: doc/BRIEF.md
# Oversampling UART with stop-bit receive filter

This block is a full-duplex asynchronous serial port. Each frame on the line has ten bits: a 0 start bit, eight data bits sent least significant bit first, and a 1 stop bit. An external overflow tick paces the port. That tick, divided by one or by two, gives a sample strobe at sixteen times the bit rate. A single frame bit therefore lasts 16 or 32 ticks, and a select input chooses which.

The transmitter does not start a frame at the moment of the write. It waits for the next rollover of a free-running divide-by-16 counter, so every bit edge on the line falls on such a rollover.

The receiver passes the line through a two-flop synchroniser and then looks for a falling edge. When it finds one, it restarts its own divide-by-16 counter. It takes three samples near the middle of each bit and uses their majority as the bit value. A frame is kept only when the receive-done flag is clear and the filter condition holds. Software-side logic clears both flags through pulse inputs.

Top module: `uart_af`

## Requirements
- R1: `txd_o` is 1 from reset onwards and whenever no frame is being sent.
- R2: A transmitted frame is a 0 start bit, the eight bits of `tx_data_i` starting with bit 0, and then a 1 stop bit. Each bit is held for one bit period.
- R3: When `rate_dbl_i` is 1, every overflow tick is a sample strobe and a bit lasts 16 ticks. When it is 0, only every second tick is a strobe and a bit lasts 32 ticks. The setting applies to both directions.
- R4: `txd_o` changes only on a rollover of the free-running transmit divide-by-16 counter. The start bit appears on the first rollover after the write is accepted, and each later bit appears on the rollover after that.
- R5: `tx_done_o` rises on the 10th rollover after an accepted write, which is the rollover that drives the stop bit. It stays 1 until a `tx_done_clr_i` pulse clears it.
- R6: A write while a frame is still in progress is ignored. The current frame is unchanged and no second frame follows it.
- R7: The value of each received bit is the 2-of-3 majority of the samples taken at receive counter states 8, 9 and 10. A single disturbed sample does not change the value.
- R8: If the voted start bit is 1, the frame is dropped and the receiver goes back to looking for a falling edge. A later valid frame is then received normally.
- R9: At the middle of the stop bit, `rx_data_o` and `rx_stop_o` are loaded and `rx_done_o` is set, but only if `rx_done_o` is 0 and either `filt_en_i` is 0 or the stop bit is 1. Otherwise the frame is dropped and the outputs keep their values.
- R10: While `rx_en_i` is 0, no frame is received and `rx_done_o` does not rise.
- R11: `rx_done_clr_i` clears `rx_done_o`. After reset, `rx_data_o`, `rx_stop_o`, `rx_done_o` and `tx_done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ovf_tick_i | input | 1 | One-cycle overflow tick from the external timer |
| rate_dbl_i | input | 1 | 1: bit rate is tick/16; 0: bit rate is tick/32 |
| tx_wr_i | input | 1 | Write strobe for the transmit byte |
| tx_data_i | input | 8 | Byte to transmit |
| tx_done_clr_i | input | 1 | Clears the transmit-done flag |
| txd_o | output | 1 | Serial transmit line |
| tx_done_o | output | 1 | Transmit-done flag |
| rxd_i | input | 1 | Serial receive line (asynchronous) |
| rx_en_i | input | 1 | Receive enable |
| filt_en_i | input | 1 | Keep only frames whose stop bit is 1 |
| rx_done_clr_i | input | 1 | Clears the receive-done flag |
| rx_data_o | output | 8 | Last accepted received byte |
| rx_stop_o | output | 1 | Stop bit of the last accepted frame |
| rx_done_o | output | 1 | Receive-done flag |

## Verification
A behavioural model in the bench tracks the rollover phase and is compared with the transmit line on every cycle.

- If the design started a frame on the write itself rather than on the next rollover, the line would fall too early.
- If it accepted a second write while busy, extra frames would appear.
- If it used the wrong divider for the rate select, the write-to-done interval would fall outside its window.

On the receive side the bench sends several kinds of frame:

- **Short glitch on the start bit.** A receiver that skipped the start vote would take this glitch as a frame.
- **One disturbed sample inside a data bit.** A receiver that used one sample instead of the vote would flip that bit.
- **Stop bit of 0 with filtering on.** A receiver that ignored the filter condition would keep this frame.
- **Frame while the done flag is still set.** A receiver that ignored the flag would overwrite the held byte.
- **Frame while receive is disabled.** A receiver that ignored the enable would keep this frame.

// File: rtl/uart_af_pkg.sv
`timescale 1ns/1ps
package uart_af_pkg;
  typedef enum logic {RX_HUNT, RX_RECV} rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_af_baud.sv
`timescale 1ns/1ps
module uart_af_baud #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_tick_i,
  input  logic rate_dbl_i,
  output logic samp_o,
  output logic roll_o
);
  localparam int CW = $clog2(OVS);

  logic          half_q;
  logic [CW-1:0] div_q;

  assign samp_o = ovf_tick_i & (rate_dbl_i | half_q);
  assign roll_o = samp_o & (div_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      div_q  <= '0;
    end else begin
      if (ovf_tick_i) half_q <= ~half_q;
      if (samp_o)     div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_af_tx.sv
`timescale 1ns/1ps
module uart_af_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              roll_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_clr_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CW      = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      left_q;
  logic               txd_q, done_q;

  assign busy_o = (left_q != '0);
  assign txd_o  = txd_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      // frame edges follow the free-running rollover, not the write
      if (wr_i && !busy_o) begin
        sh_q   <= {1'b1, data_i, 1'b0};
        left_q <= CW'(FRAME_W);
      end else if (roll_i && busy_o) begin
        txd_q  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
      if (roll_i && left_q == CW'(1)) done_q <= 1'b1;
      else if (done_clr_i)            done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_af_rx.sv
`timescale 1ns/1ps
module uart_af_rx
  import uart_af_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              filt_en_i,
  input  logic              done_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_o,
  output logic              done_o
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DATA_W + 2);
  localparam int MID = OVS / 2;

  rx_state_e         state_q;
  logic              sync1_q, sync2_q, prev_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic              v0_q, v1_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              stop_q, done_q;
  logic              fall, bit_v;

  assign fall   = prev_q & ~sync2_q;
  assign bit_v  = vote3(v0_q, v1_q, sync2_q);
  assign data_o = data_q;
  assign stop_o = stop_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rxd_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      idx_q   <= '0;
      v0_q    <= 1'b1;
      v1_q    <= 1'b1;
      sh_q    <= '0;
      data_q  <= '0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (done_clr_i) done_q <= 1'b0;
      if (!rx_en_i) begin
        state_q <= RX_HUNT;
      end else begin
        case (state_q)
          RX_HUNT: if (fall) begin
            state_q <= RX_RECV;
            cnt_q   <= '0;
            idx_q   <= '0;
          end
          RX_RECV: if (samp_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(MID))     v0_q <= sync2_q;
            if (cnt_q == CW'(MID + 1)) v1_q <= sync2_q;
            if (cnt_q == CW'(MID + 2)) begin
              idx_q <= idx_q + 1'b1;
              if (idx_q == '0) begin
                if (bit_v) state_q <= RX_HUNT;  // false start
              end else if (idx_q <= IW'(DATA_W)) begin
                sh_q <= {bit_v, sh_q[DATA_W-1:1]};
              end else begin
                state_q <= RX_HUNT;
                if (!done_q && (!filt_en_i || bit_v)) begin
                  data_q <= sh_q;
                  stop_q <= bit_v;
                  done_q <= 1'b1;
                end
              end
            end
          end
          default: state_q <= RX_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_af.sv
`timescale 1ns/1ps
module uart_af #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovf_tick_i,
  input  logic              rate_dbl_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_done_clr_i,
  output logic              txd_o,
  output logic              tx_done_o,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              filt_en_i,
  input  logic              rx_done_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_stop_o,
  output logic              rx_done_o
);
  logic samp, roll, tx_busy;

  uart_af_baud #(.OVS(OVS)) u_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovf_tick_i (ovf_tick_i),
    .rate_dbl_i (rate_dbl_i),
    .samp_o     (samp),
    .roll_o     (roll)
  );

  uart_af_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .roll_i     (roll),
    .wr_i       (tx_wr_i),
    .data_i     (tx_data_i),
    .done_clr_i (tx_done_clr_i),
    .txd_o      (txd_o),
    .busy_o     (tx_busy),
    .done_o     (tx_done_o)
  );

  uart_af_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_i     (samp),
    .rxd_i      (rxd_i),
    .rx_en_i    (rx_en_i),
    .filt_en_i  (filt_en_i),
    .done_clr_i (rx_done_clr_i),
    .data_o     (rx_data_o),
    .stop_o     (rx_stop_o),
    .done_o     (rx_done_o)
  );
endmodule

// File: rtl/uart_af_chk.sv
`timescale 1ns/1ps
module uart_af_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              roll,
  input logic              tx_busy,
  input logic              txd_o,
  input logic              tx_done_o,
  input logic              rx_en_i,
  input logic              filt_en_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_stop_o,
  input logic              rx_done_o
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  a_r4_edge_on_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(roll));

  a_r5_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_done_o) |-> $fell(tx_busy));

  a_r9_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> $stable(rx_data_o) && $stable(rx_stop_o));

  a_r9_filter_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> (!$past(filt_en_i) || rx_stop_o));

  a_r10_no_rx_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !$rose(rx_done_o));
endmodule

bind uart_af uart_af_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .roll      (roll),
  .tx_busy   (tx_busy),
  .txd_o     (txd_o),
  .tx_done_o (tx_done_o),
  .rx_en_i   (rx_en_i),
  .filt_en_i (filt_en_i),
  .rx_data_o (rx_data_o),
  .rx_stop_o (rx_stop_o),
  .rx_done_o (rx_done_o)
);

// File: tb/uart_af_tb_top.sv
`timescale 1ns/1ps
module uart_af_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0, ovf = 1'b0, dbl = 1'b1;
  logic       wr = 1'b0, tclr = 1'b0, rxd = 1'b1, rx_en = 1'b0, filt = 1'b0, rclr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, tdone, rstop, rdone;
  logic [7:0] rdata;

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  logic [7:0] e_data = 8'h00;
  bit         e_stop = 1'b0, e_done = 1'b0;

  always #4 clk = ~clk;

  uart_af dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ovf_tick_i(ovf), .rate_dbl_i(dbl),
    .tx_wr_i(wr), .tx_data_i(wdata), .tx_done_clr_i(tclr),
    .txd_o(txd), .tx_done_o(tdone),
    .rxd_i(rxd), .rx_en_i(rx_en), .filt_en_i(filt), .rx_done_clr_i(rclr),
    .rx_data_o(rdata), .rx_stop_o(rstop), .rx_done_o(rdone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // overflow tick: one cycle in two
  initial forever begin
    @(negedge clk);
    ovf = rst_n ? ~ovf : 1'b0;
  end

  // behavioural transmit model
  int m_ovf = 0, m_samp = 0;
  bit m_txd = 1'b1, m_tdone = 1'b0;
  bit m_q[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovf = 0; m_samp = 0; m_txd = 1'b1; m_tdone = 1'b0; m_q.delete();
    end else begin
      bit s, r, set;
      s = ovf && (dbl || (m_ovf % 2 == 1));
      r = s && (m_samp % 16 == 15);
      if (ovf) m_ovf++;
      if (s)   m_samp++;
      set = 1'b0;
      if (wr && m_q.size() == 0) begin
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(wdata[i]);
        m_q.push_back(1'b1);
      end else if (r && m_q.size() != 0) begin
        m_txd = m_q.pop_front();
        if (m_q.size() == 0) set = 1'b1;
      end
      if (set)       m_tdone = 1'b1;
      else if (tclr) m_tdone = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check(txd == m_txd, "R2 R4 txd", txd, m_txd);
      check(tdone == m_tdone, "R5 tx_done", tdone, m_tdone);
    end
  end

  task automatic tx_frame(input logic [7:0] d, input int lo, input int hi, input bit intrude);
    int n = 0;
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    while (!tdone && n < 2000) begin
      @(negedge clk); n++;
      if (intrude && n == 100) begin wr = 1'b1; wdata = 8'hFF; end
      if (intrude && n == 101) wr = 1'b0;
    end
    check(n >= lo && n <= hi, "R3 write-to-done cycles", n, lo);
    @(negedge clk); tclr = 1'b1;
    @(negedge clk); tclr = 1'b0;
    check(tdone == 1'b0, "R5 clear", tdone, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit stopb, input bit glitch);
    int bc = dbl ? 32 : 64;
    logic [9:0] f = {stopb, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < bc; c++) begin
        rxd = (glitch && i == 3 && (c == 19 || c == 20)) ? ~f[i] : f[i];
        @(negedge clk);
      end
    end
    if (rx_en && !e_done && (!filt || stopb)) begin
      e_data = d; e_stop = stopb; e_done = 1'b1;
    end
    rxd = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic rx_check(input string req);
    check(rdone == e_done, {req, " rx_done"}, rdone, e_done);
    check(rdata == e_data, {req, " rx_data"}, rdata, e_data);
    check(rstop == e_stop, {req, " rx_stop"}, rstop, e_stop);
  endtask

  task automatic rx_clear();
    @(negedge clk); rclr = 1'b1;
    @(negedge clk); rclr = 1'b0;
    e_done = 1'b0;
    check(rdone == 1'b0, "R11 rx clear", rdone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11 reset state
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(tdone == 1'b0, "R11 reset tx_done", tdone, 0);
    check(rdone == 1'b0 && rdata == 8'h00 && rstop == 1'b0, "R11 reset rx", rdata, 0);
    repeat (37) @(negedge clk);

    // transmit: R2 R4 R5 under both rates, R6 intrusion
    tx_frame(8'h3C, 289, 320, 1'b0);
    tx_frame(8'hA7, 289, 320, 1'b1);     // R6 write during frame
    repeat (100) @(negedge clk);
    check(txd == 1'b1 && tdone == 1'b0, "R6 no extra frame", txd, 1);
    dbl = 1'b0;
    tx_frame(8'h81, 577, 640, 1'b0);     // R3 slow rate
    dbl = 1'b1;
    repeat (20) @(negedge clk);
    check(txd == 1'b1, "R1 idle after frames", txd, 1);

    // receive
    rx_en = 1'b1;
    repeat (40) @(negedge clk);
    rx_frame(8'hA5, 1'b1, 1'b0); rx_check("R9 accept");
    rx_frame(8'h5A, 1'b1, 1'b0); rx_check("R9 flag set discard");
    rx_clear();
    filt = 1'b1;
    rx_frame(8'h33, 1'b0, 1'b0); rx_check("R9 filter drop");
    rx_frame(8'h96, 1'b1, 1'b0); rx_check("R9 filter keep");
    rx_clear();
    filt = 1'b0;
    rx_frame(8'h0F, 1'b0, 1'b0); rx_check("R9 stop0 unfiltered");
    rx_clear();
    // R8 false start
    rxd = 1'b0; repeat (4) @(negedge clk);
    rxd = 1'b1; repeat (64) @(negedge clk);
    rx_check("R8 false start");
    rx_frame(8'hC3, 1'b1, 1'b0); rx_check("R8 after false start");
    rx_clear();
    rx_frame(8'h6E, 1'b1, 1'b1); rx_check("R7 majority");
    rx_clear();
    rx_en = 1'b0;
    rx_frame(8'h11, 1'b1, 1'b0); rx_check("R10 disabled");
    rx_en = 1'b1;
    repeat (40) @(negedge clk);
    dbl = 1'b0;
    repeat (40) @(negedge clk);
    rx_frame(8'hE7, 1'b1, 1'b0); rx_check("R3 slow rate rx");
    dbl = 1'b1;

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule